// File: doc/BRIEF.md
# Battery Thermistor Temperature Zone Monitor

This block sorts a battery's temperature into one of six zones, using the thermistor reading that an ADC produces, and derives from that zone the adjustments a linear charger needs. The thermistor divider gives a lower voltage as the battery gets warmer. A larger code therefore means a colder battery. Five programmable byte-wide thresholds (open, cold, cool, warm, hot) are compared against the most significant byte of each ADC result. The zone changes only when the ADC strobes a new thermistor result.

From the registered zone and a mode select, the block produces several outputs: a charge-hold and a safety-timer-hold, a fast-charge current code that is scaled down in the cool zone, and a request to lower the regulation voltage and inhibit termination in the warm zone. It also keeps sticky fault bits for the hot, cold and open conditions and raises an interrupt pulse on every zone change. A separate one-cycle update pulse goes to the charge-current sequencer whenever the zone that controls charging changes. Fault and interrupt reporting work in every mode, including the monitor-only modes that leave charging alone.

Top module: `thermal_zone_monitor`

## Requirements
- R1: Let t be the top 8 bits of the ADC code. The zone is OPEN (5) when t > open threshold, else COLD (4) when t > cold, else COOL (3) when t > cool, else NORMAL (2) when t >= warm, else WARM (1) when t >= hot, else HOT (0).
- R2: The zone is updated only on a cycle with the valid strobe high. The low 8 bits of the ADC code have no effect on the zone.
- R3: In mode 0 (full) and mode 1 (hot/cold only), the charge hold is high in HOT, COLD and OPEN, and the timer hold is high in HOT and COLD only. In modes 2 and 3 (monitor only), both holds stay low.
- R4: In mode 0 with the zone COOL, the effective current code is floor(code × (frac+1) / 8), where frac is the 3-bit cool scaling code. Otherwise the code passes through unchanged. For example, code 12 with frac 0 gives 1.
- R5: In mode 0 with the zone WARM, the reduce-voltage request and the termination inhibit are high. They are low in all other cases.
- R6: In mode 1, the COOL and WARM zones give the same charge outputs as NORMAL.
- R7: After a strobe whose zone differs from the previous zone, the interrupt is high for one cycle. This holds in every mode.
- R8: The current-update pulse is high for one cycle after a strobe that changes the control zone. The control zone is the zone as seen through the mode: mode 1 maps COOL and WARM to NORMAL, and modes 2 and 3 map every zone to NORMAL.
- R9: Fault bits are hot (bit 0), cold (bit 1) and open (bit 2). Each is set by a strobe that classifies into its zone, in any mode. A bit stays set until a read strobe clears it. A set in the same cycle as a read takes priority.
- R10: After reset, the zone is NORMAL, the faults are clear, both pulses are low and the holds are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_valid | input | 1 | Strobe: new thermistor ADC result |
| adc_code | input | CODE_W | Thermistor ADC result |
| thr_open | input | THR_W | Open-circuit threshold |
| thr_cold | input | THR_W | Cold threshold |
| thr_cool | input | THR_W | Cool threshold |
| thr_warm | input | THR_W | Warm threshold |
| thr_hot | input | THR_W | Hot threshold |
| mode | input | 2 | 0 full, 1 hot/cold only, 2-3 monitor only |
| ichg_code | input | I_W | Fast-charge current code in steps |
| cool_frac | input | F_W | Cool scaling code, fraction (frac+1)/8 |
| fault_read | input | 1 | Read strobe that clears the fault bits |
| zone | output | 3 | Registered temperature zone |
| chg_hold | output | 1 | Suspend charging |
| tmr_hold | output | 1 | Suspend safety timers |
| ichg_eff | output | I_W | Effective current code |
| vreg_reduce | output | 1 | Lower the regulation voltage |
| term_inhibit | output | 1 | Inhibit termination |
| fault | output | 3 | Sticky open/cold/hot bits |
| irq | output | 1 | Zone-change interrupt pulse |
| cur_upd | output | 1 | Control-zone change pulse for the sequencer |

## Verification
The zone, the interrupt, the update pulse and the fault bits are registered at the edge that samples the strobe, so they are due one clock edge after the strobe is presented. The holds, the scaled current and the warm requests follow combinationally from the registered zone and the live configuration, so they are due in the same cycle as a configuration change. The bench drives inputs on falling edges and reads results on the next falling edge. It also checks in the idle cycle that follows that the pulses have dropped and that the zone has not moved while the ADC code changed without a strobe.

// File: rtl/tzm_pkg.sv
package tzm_pkg;
  typedef enum logic [2:0] {
    Z_HOT  = 3'd0,
    Z_WARM = 3'd1,
    Z_NORM = 3'd2,
    Z_COOL = 3'd3,
    Z_COLD = 3'd4,
    Z_OPEN = 3'd5
  } zone_e;

  localparam logic [1:0] M_FULL    = 2'd0;
  localparam logic [1:0] M_HOTCOLD = 2'd1;

  // Zone as seen by the charge controls under a given mode (R6, R8)
  function automatic zone_e ctl_zone(input zone_e z, input logic [1:0] m);
    zone_e r;
    if (m == M_FULL) r = z;
    else if (m == M_HOTCOLD) r = ((z == Z_WARM) || (z == Z_COOL)) ? Z_NORM : z;
    else r = Z_NORM;
    return r;
  endfunction
endpackage

// File: rtl/tzm_classify.sv
module tzm_classify
  import tzm_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic [THR_W-1:0] level,
  input  logic [THR_W-1:0] thr_open,
  input  logic [THR_W-1:0] thr_cold,
  input  logic [THR_W-1:0] thr_cool,
  input  logic [THR_W-1:0] thr_warm,
  input  logic [THR_W-1:0] thr_hot,
  output zone_e            zone
);
  // Higher level means colder battery: check from the cold end down
  always_comb begin
    if (level > thr_open)       zone = Z_OPEN;
    else if (level > thr_cold)  zone = Z_COLD;
    else if (level > thr_cool)  zone = Z_COOL;
    else if (level >= thr_warm) zone = Z_NORM;
    else if (level >= thr_hot)  zone = Z_WARM;
    else                        zone = Z_HOT;
  end
endmodule

// File: rtl/tzm_scale.sv
module tzm_scale #(
  parameter int I_W = 9,
  parameter int F_W = 3
) (
  input  logic [I_W-1:0] ichg,
  input  logic [F_W-1:0] frac,
  output logic [I_W-1:0] scaled
);
  localparam int P_W = I_W + F_W + 1;

  generate
    if (F_W == 0) begin : g_pass
      assign scaled = ichg;
    end else begin : g_mul
      logic [P_W-1:0] mult;
      logic [P_W-1:0] prod;
      assign mult   = P_W'(frac) + P_W'(1);
      assign prod   = P_W'(ichg) * mult;
      // floor division by 2^F_W: whole current steps only
      assign scaled = prod[F_W +: I_W];
    end
  endgenerate
endmodule

// File: rtl/tzm_flags.sv
module tzm_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  always_comb begin
    q_d = (clr ? '0 : q) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/thermal_zone_monitor.sv
module thermal_zone_monitor
  import tzm_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int THR_W  = 8,
  parameter int I_W    = 9,
  parameter int F_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [THR_W-1:0]  thr_open,
  input  logic [THR_W-1:0]  thr_cold,
  input  logic [THR_W-1:0]  thr_cool,
  input  logic [THR_W-1:0]  thr_warm,
  input  logic [THR_W-1:0]  thr_hot,
  input  logic [1:0]        mode,
  input  logic [I_W-1:0]    ichg_code,
  input  logic [F_W-1:0]    cool_frac,
  input  logic              fault_read,
  output logic [2:0]        zone,
  output logic              chg_hold,
  output logic              tmr_hold,
  output logic [I_W-1:0]    ichg_eff,
  output logic              vreg_reduce,
  output logic              term_inhibit,
  output logic [2:0]        fault,
  output logic              irq,
  output logic              cur_upd
);
  localparam int LSB = CODE_W - THR_W;

  zone_e          zone_new, zone_q, zone_d, cz;
  logic           irq_d, upd_d;
  logic [2:0]     fault_set;
  logic [I_W-1:0] ichg_scaled;

  tzm_classify #(.THR_W(THR_W)) u_cls (
    .level    (adc_code[CODE_W-1:LSB]),
    .thr_open (thr_open),
    .thr_cold (thr_cold),
    .thr_cool (thr_cool),
    .thr_warm (thr_warm),
    .thr_hot  (thr_hot),
    .zone     (zone_new)
  );

  tzm_scale #(.I_W(I_W), .F_W(F_W)) u_scl (
    .ichg   (ichg_code),
    .frac   (cool_frac),
    .scaled (ichg_scaled)
  );

  // next state
  always_comb begin
    zone_d    = adc_valid ? zone_new : zone_q;
    irq_d     = adc_valid && (zone_new != zone_q);
    upd_d     = adc_valid && (ctl_zone(zone_new, mode) != ctl_zone(zone_q, mode));
    fault_set = {3{adc_valid}} & {zone_new == Z_OPEN, zone_new == Z_COLD, zone_new == Z_HOT};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q  <= Z_NORM;
      irq     <= 1'b0;
      cur_upd <= 1'b0;
    end else begin
      zone_q  <= zone_d;
      irq     <= irq_d;
      cur_upd <= upd_d;
    end
  end

  tzm_flags #(.N(3)) u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fault_set),
    .clr   (fault_read),
    .q     (fault)
  );

  // charge controls from registered zone and live configuration
  always_comb begin
    cz           = ctl_zone(zone_q, mode);
    chg_hold     = (cz == Z_HOT) || (cz == Z_COLD) || (cz == Z_OPEN);
    tmr_hold     = (cz == Z_HOT) || (cz == Z_COLD);
    vreg_reduce  = (cz == Z_WARM);
    term_inhibit = (cz == Z_WARM);
    ichg_eff     = (cz == Z_COOL) ? ichg_scaled : ichg_code;
    zone         = zone_q;
  end
endmodule

// File: rtl/tzm_checker.sv
module tzm_checker #(
  parameter int I_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           adc_valid,
  input logic [1:0]     mode,
  input logic [I_W-1:0] ichg_code,
  input logic           fault_read,
  input logic [2:0]     zone,
  input logic           chg_hold,
  input logic           tmr_hold,
  input logic [I_W-1:0] ichg_eff,
  input logic           vreg_reduce,
  input logic           term_inhibit,
  input logic [2:0]     fault,
  input logic           irq,
  input logic           cur_upd
);
  a_r2_zone_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_valid |=> $stable(zone));

  a_r7_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |=> (irq == (zone != $past(zone))));

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(adc_valid));

  a_r8_upd_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cur_upd |-> irq);

  a_r3_timer_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hold |-> chg_hold);

  a_r3_monitor_free: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (!chg_hold && !vreg_reduce));

  a_r4_scale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ichg_eff <= ichg_code);

  a_r5_warm_only: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_reduce || term_inhibit) |-> (zone == 3'd1 && mode == 2'd0));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_read |=> ((fault & $past(fault)) == $past(fault)));
endmodule

bind thermal_zone_monitor tzm_checker #(.I_W(I_W)) u_tzm_chk (.*);

// File: tb/thermal_zone_monitor_bench.sv
module thermal_zone_monitor_bench;
  localparam int OPN = 192, CLD = 125, COL = 110, WRM = 57, HT = 39;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adc_valid;
  logic [15:0] adc_code;
  logic [1:0]  mode;
  logic [8:0]  ichg_code;
  logic [2:0]  cool_frac;
  logic        fault_read;
  logic [2:0]  zone;
  logic        chg_hold, tmr_hold, vreg_reduce, term_inhibit, irq, cur_upd;
  logic [8:0]  ichg_eff;
  logic [2:0]  fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thermal_zone_monitor u_thermal_zone_monitor (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_code(adc_code),
    .thr_open(8'(OPN)), .thr_cold(8'(CLD)), .thr_cool(8'(COL)),
    .thr_warm(8'(WRM)), .thr_hot(8'(HT)), .mode(mode),
    .ichg_code(ichg_code), .cool_frac(cool_frac), .fault_read(fault_read),
    .zone(zone), .chg_hold(chg_hold), .tmr_hold(tmr_hold), .ichg_eff(ichg_eff),
    .vreg_reduce(vreg_reduce), .term_inhibit(term_inhibit), .fault(fault),
    .irq(irq), .cur_upd(cur_upd)
  );

  function automatic int zexp(input int t);
    if (t > OPN) return 5;
    if (t > CLD) return 4;
    if (t > COL) return 3;
    if (t >= WRM) return 2;
    if (t >= HT) return 1;
    return 0;
  endfunction

  function automatic int cexp(input int z, input int m);
    if (m == 0) return z;
    if (m == 1) return (z == 1 || z == 3) ? 2 : z;
    return 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int t, input int lo);
    @(negedge clk);
    adc_code  = {t[7:0], lo[7:0]};
    adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic check_ctl(input int z, input int m);
    int c;
    c = cexp(z, m);
    chk("R3 chg_hold", int'(chg_hold), int'(c == 0 || c == 4 || c == 5));
    chk("R3 tmr_hold", int'(tmr_hold), int'(c == 0 || c == 4));
    chk("R5 vreg_reduce", int'(vreg_reduce), int'(c == 1));
    chk("R5 term_inhibit", int'(term_inhibit), int'(c == 1));
    chk("R4 R6 ichg_eff", int'(ichg_eff),
        (c == 3) ? (int'(ichg_code) * (int'(cool_frac) + 1)) / 8 : int'(ichg_code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int prev;
    rst_n = 1'b0; adc_valid = 1'b0; adc_code = '0; mode = 2'd0;
    ichg_code = 9'd80; cool_frac = 3'd3; fault_read = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 zone", int'(zone), 2);
    chk("R10 fault", int'(fault), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 cur_upd", int'(cur_upd), 0);
    chk("R10 chg_hold", int'(chg_hold), 0);
    chk("R10 ichg_eff", int'(ichg_eff), 80);

    prev = 2;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int dir = 0; dir < 2; dir++) begin
        for (int i = 0; i < 256; i++) begin
          int t, z;
          t = (dir == 0) ? i : 255 - i;
          z = zexp(t);
          strobe(t, (t * 37) ^ 8'h5A);
          chk("R1 zone", int'(zone), z);
          chk("R7 irq", int'(irq), int'(z != prev));
          chk("R8 cur_upd", int'(cur_upd), int'(cexp(z, m) != cexp(prev, m)));
          check_ctl(z, m);
          // R2: code moves without a strobe, zone must not
          adc_code = ~adc_code;
          @(negedge clk);
          chk("R2 zone held", int'(zone), z);
          chk("R7 irq one cycle", int'(irq), 0);
          chk("R8 cur_upd one cycle", int'(cur_upd), 0);
          prev = z;
        end
      end
    end

    // R2: low byte alone does not move the zone (t=COL is NORMAL, t=COL+1 is COOL)
    mode = 2'd0;
    strobe(COL, 8'hFF);
    chk("R2 low bits", int'(zone), 2);
    strobe(COL, 8'h00);
    chk("R2 low bits", int'(zone), 2);

    // R9: every fault zone visited in sweeps
    chk("R9 sticky all", int'(fault), 7);
    @(negedge clk); fault_read = 1'b1;
    @(negedge clk); fault_read = 1'b0;
    chk("R9 read clear", int'(fault), 0);
    // set wins over a read in the same cycle
    @(negedge clk);
    adc_code = {8'(HT - 1), 8'h00}; adc_valid = 1'b1; fault_read = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0; fault_read = 1'b0;
    chk("R9 set priority", int'(fault), 1);
    strobe(OPN + 1, 0);
    chk("R9 open bit", int'(fault), 5);
    mode = 2'd2;
    strobe(CLD + 1, 0);
    chk("R9 cold in monitor mode", int'(fault), 7);

    // R4 cool scaling sweep
    mode = 2'd0;
    strobe(COL + 1, 0);
    chk("R4 cool zone", int'(zone), 3);
    for (int k = 0; k < 8; k++) begin
      for (int ic = 0; ic < 512; ic += 13) begin
        @(negedge clk);
        ichg_code = 9'(ic); cool_frac = 3'(k);
        @(negedge clk);
        chk("R4 scaled", int'(ichg_eff), (ic * (k + 1)) / 8);
      end
    end
    @(negedge clk); ichg_code = 9'd12; cool_frac = 3'd0;
    @(negedge clk);
    chk("R4 15mA x 1/8", int'(ichg_eff), 1);
    // R6: hot/cold mode passes cool current unchanged
    mode = 2'd1;
    @(negedge clk);
    chk("R6 cool as normal", int'(ichg_eff), 12);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule